// File: doc/BRIEF.md
# Streaming Radix-2 Butterfly Stage

This block is one pipelined stage of a streaming decimation-in-time radix-2 FFT. It takes one complex sample per clock, qualified by a valid flag. It returns one complex sample per accepted input once it has filled. The stage index `STAGE` sets the butterfly span `H = 2^(STAGE-1)`. It also sets the depth of the pairing memory, which holds `H` complex words, and the twiddle stride `2^(LOG2N-STAGE)`. Chaining `LOG2N` such stages, with `STAGE` running from 1 up to `LOG2N`, gives a full transform of size `2^LOG2N`. The chain expects its input already in bit-reversed order.

All butterfly work of the stage goes through a single complex multiplier and adder pair. The valid input samples are grouped in blocks of `2H`. The first half of a block is parked in the memory. Each sample of the second half is then combined with the parked sample at the same offset. The sum leaves at once. The difference goes back into the freed memory slot and leaves while the next block's first half is arriving. This keeps exactly one output per accepted input, and the output stream is the input stream delayed by `H` samples.

Top module: `r2s_fft_stage`

## Requirements
- R1: After reset `out_valid` is low and `out_re`/`out_im` are zero. The first `H` valid input samples produce no output (`out_valid` stays low in the cycle after each of them).
- R2: Once `H` valid samples have been accepted, every cycle with `in_valid` high is followed one clock later by `out_valid` high. A cycle with `in_valid` low is followed by `out_valid` low.
- R3: Valid samples are counted from reset in blocks of `2H`. The sample at offset `k` (0 ≤ k < H) of a block's first half is paired with the sample at offset `H+k` of the same block.
- R4: For a pair (a, b) with twiddle w, the output on the cycle after b is accepted is `a + w·b`.
- R5: The value `a − w·b` for offset `k` is emitted on the cycle after the `k`-th valid sample of the following block. The differences therefore leave in the order k = 0..H−1, after all the sums of their block.
- R6: The twiddle for offset `k` is `w = cos θ − j·sin θ`, with `θ = 2π·k·2^(LOG2N−STAGE) / 2^LOG2N`. Its real part (cos) and imaginary part (−sin) are each rounded to nearest in signed fixed point with `CF` fraction bits, so offset 0 uses (2^CF, 0).
- R7: The products are computed as `re = b_re·w_re − b_im·w_im` and `im = b_re·w_im + b_im·w_re`. Each is shifted right arithmetically by `CF` bits, which rounds toward minus infinity, before the add and the subtract.
- R8: Each output component saturates to the signed `DW`-bit range [−2^(DW−1), 2^(DW−1)−1] instead of wrapping.
- R9: A cycle with `in_valid` low does not advance the block position or the pairing. The output data hold their previous value in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample qualifier |
| in_re | input | DW | Input real part, signed |
| in_im | input | DW | Input imaginary part, signed |
| out_valid | output | 1 | Output sample qualifier |
| out_re | output | DW | Output real part, signed |
| out_im | output | DW | Output imaginary part, signed |

## Verification
The bench drives three kinds of input. Impulses show whether each sample is paired with the right partner, since an off-by-one pairing moves the energy to the wrong output slot. Second-half-only blocks expose the twiddle at every offset: a wrong stride, a sign slip in −sin or a swapped real/imag product would all show up in the sums. Full-scale blocks drive both the sum and the difference past the rails, so a design that wraps instead of clamping gives a flipped sign. Idle cycles are inserted mid-block, so a counter that advanced on invalid cycles would pair the wrong samples and emit outputs where none are due.

// File: rtl/r2s_pkg.sv
package r2s_pkg;

   typedef enum logic {
      PH_FILL = 1'b0,
      PH_PAIR = 1'b1
   } phase_e;

   localparam real TWO_PI = 6.283185307179586;

   // Round a real to the nearest integer after scaling by 2^frac.
   function automatic int to_fix(input real x, input int frac);
      real s;
      s = x * (2.0 ** frac);
      return (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(0.5 - s);
   endfunction

endpackage

// File: rtl/r2s_ctrl.sv
module r2s_ctrl #(
   parameter int STAGE = 3,
   localparam int KW = (STAGE > 1) ? STAGE - 1 : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic [KW-1:0]     k_idx,
   output r2s_pkg::phase_e   phase,
   output logic              emit
);

   logic [STAGE-1:0] cnt_q;
   logic             primed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         primed_q <= 1'b0;
      end else if (in_valid) begin
         cnt_q <= cnt_q + STAGE'(1);
         if (cnt_q[STAGE-1]) primed_q <= 1'b1;
      end
   end

   assign phase = cnt_q[STAGE-1] ? r2s_pkg::PH_PAIR : r2s_pkg::PH_FILL;
   assign emit  = in_valid && (primed_q || cnt_q[STAGE-1]);

   generate
      if (STAGE == 1) begin : g_span1
         assign k_idx = 1'b0;
      end else begin : g_spanN
         assign k_idx = cnt_q[KW-1:0];
      end
   endgenerate

endmodule

// File: rtl/r2s_twiddle_rom.sv
module r2s_twiddle_rom #(
   parameter int LOG2N = 9,
   parameter int STAGE = 3,
   parameter int CW    = 12,
   parameter int CF    = 10,
   localparam int KW   = (STAGE > 1) ? STAGE - 1 : 1,
   localparam int SPAN = 2 ** (STAGE - 1),
   localparam int ROWS = 2 ** KW
) (
   input  logic [KW-1:0]        k_idx,
   output logic signed [CW-1:0] w_re,
   output logic signed [CW-1:0] w_im
);

   logic signed [CW-1:0] re_tab [ROWS];
   logic signed [CW-1:0] im_tab [ROWS];

   generate
      for (genvar i = 0; i < ROWS; i++) begin : g_row
         localparam int  M  = (i % SPAN) * (2 ** (LOG2N - STAGE));
         localparam real TH = r2s_pkg::TWO_PI * M / (2.0 ** LOG2N);
         localparam int  CR = r2s_pkg::to_fix($cos(TH), CF);
         localparam int  CI = r2s_pkg::to_fix(-$sin(TH), CF);
         assign re_tab[i] = CW'(CR);
         assign im_tab[i] = CW'(CI);
      end
   endgenerate

   assign w_re = re_tab[k_idx];
   assign w_im = im_tab[k_idx];

endmodule

// File: rtl/r2s_butterfly.sv
module r2s_butterfly #(
   parameter int DW = 12,
   parameter int CW = 12,
   parameter int CF = 10,
   localparam int PW = DW + CW + 1,
   localparam int SW = PW + 1
) (
   input  logic signed [DW-1:0] a_re,
   input  logic signed [DW-1:0] a_im,
   input  logic signed [DW-1:0] b_re,
   input  logic signed [DW-1:0] b_im,
   input  logic signed [CW-1:0] w_re,
   input  logic signed [CW-1:0] w_im,
   output logic signed [DW-1:0] up_re,
   output logic signed [DW-1:0] up_im,
   output logic signed [DW-1:0] lo_re,
   output logic signed [DW-1:0] lo_im
);

   localparam logic signed [SW-1:0] MAXV = SW'((1 <<< (DW - 1)) - 1);
   localparam logic signed [SW-1:0] MINV = SW'(-(1 <<< (DW - 1)));

   function automatic logic signed [DW-1:0] clamp(input logic signed [SW-1:0] v);
      if (v > MAXV) return MAXV[DW-1:0];
      if (v < MINV) return MINV[DW-1:0];
      return v[DW-1:0];
   endfunction

   logic signed [PW-1:0] pr, pi, ps_re, ps_im;
   logic signed [SW-1:0] su_re, su_im, df_re, df_im;

   always_comb begin
      pr    = PW'(b_re) * PW'(w_re) - PW'(b_im) * PW'(w_im);
      pi    = PW'(b_re) * PW'(w_im) + PW'(b_im) * PW'(w_re);
      ps_re = pr >>> CF;
      ps_im = pi >>> CF;
      su_re = SW'(a_re) + SW'(ps_re);
      su_im = SW'(a_im) + SW'(ps_im);
      df_re = SW'(a_re) - SW'(ps_re);
      df_im = SW'(a_im) - SW'(ps_im);
      up_re = clamp(su_re);
      up_im = clamp(su_im);
      lo_re = clamp(df_re);
      lo_im = clamp(df_im);
   end

endmodule

// File: rtl/r2s_delay_mem.sv
module r2s_delay_mem #(
   parameter int AW = 2,
   parameter int WW = 24
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [WW-1:0] wdata,
   output logic [WW-1:0] rdata
);

   logic [WW-1:0] mem [2 ** AW];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/r2s_fft_stage.sv
module r2s_fft_stage #(
   parameter int LOG2N = 9,
   parameter int STAGE = 3,
   parameter int DW    = 12,
   parameter int CW    = 12,
   parameter int CF    = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] in_re,
   input  logic signed [DW-1:0] in_im,
   output logic                 out_valid,
   output logic signed [DW-1:0] out_re,
   output logic signed [DW-1:0] out_im
);

   localparam int KW = (STAGE > 1) ? STAGE - 1 : 1;

   generate
      if (STAGE < 1 || STAGE > LOG2N) begin : g_bad_stage
         $error("STAGE must lie in 1..LOG2N");
      end
      if (CF > CW - 2) begin : g_bad_coef
         $error("CW must hold the value 1.0 with CF fraction bits");
      end
      if (DW < 4) begin : g_bad_dw
         $error("DW too small");
      end
   endgenerate

   logic [KW-1:0]        k_idx;
   r2s_pkg::phase_e      phase;
   logic                 emit;
   logic signed [CW-1:0] tw_re, tw_im;
   logic [2*DW-1:0]      rd_word, wr_word;
   logic signed [DW-1:0] a_re, a_im;
   logic signed [DW-1:0] up_re, up_im, lo_re, lo_im;

   r2s_ctrl #(.STAGE(STAGE)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .k_idx    (k_idx),
      .phase    (phase),
      .emit     (emit)
   );

   r2s_twiddle_rom #(.LOG2N(LOG2N), .STAGE(STAGE), .CW(CW), .CF(CF)) u_rom (
      .k_idx (k_idx),
      .w_re  (tw_re),
      .w_im  (tw_im)
   );

   r2s_delay_mem #(.AW(KW), .WW(2 * DW)) u_mem (
      .clk   (clk),
      .we    (in_valid),
      .addr  (k_idx),
      .wdata (wr_word),
      .rdata (rd_word)
   );

   assign a_re = signed'(rd_word[2*DW-1:DW]);
   assign a_im = signed'(rd_word[DW-1:0]);

   r2s_butterfly #(.DW(DW), .CW(CW), .CF(CF)) u_bfly (
      .a_re  (a_re),
      .a_im  (a_im),
      .b_re  (in_re),
      .b_im  (in_im),
      .w_re  (tw_re),
      .w_im  (tw_im),
      .up_re (up_re),
      .up_im (up_im),
      .lo_re (lo_re),
      .lo_im (lo_im)
   );

   // Pair phase parks the difference; fill phase parks the new sample.
   assign wr_word = (phase == r2s_pkg::PH_PAIR) ? {lo_re, lo_im} : {in_re, in_im};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_re    <= '0;
         out_im    <= '0;
      end else begin
         out_valid <= emit;
         if (emit) begin
            if (phase == r2s_pkg::PH_PAIR) begin
               out_re <= up_re;
               out_im <= up_im;
            end else begin
               out_re <= a_re;
               out_im <= a_im;
            end
         end
      end
   end

endmodule

// File: rtl/r2s_fft_stage_chk.sv
module r2s_fft_stage_chk #(
   parameter int STAGE = 3,
   parameter int DW    = 12,
   parameter int CW    = 12,
   parameter int CF    = 10,
   localparam int KW   = (STAGE > 1) ? STAGE - 1 : 1,
   localparam int SPAN = 2 ** (STAGE - 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic                 out_valid,
   input logic signed [DW-1:0] out_re,
   input logic signed [DW-1:0] out_im,
   input logic [KW-1:0]        k_idx,
   input logic signed [CW-1:0] tw_re,
   input logic signed [CW-1:0] tw_im
);

   logic [KW:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= '0;
      else if (in_valid && seen_q != (KW+1)'(SPAN)) seen_q <= seen_q + (KW+1)'(1);
   end

   AST_FILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && seen_q != (KW+1)'(SPAN)) |=> !out_valid);   // R1
   AST_PRIMED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && seen_q == (KW+1)'(SPAN)) |=> out_valid);    // R2
   AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);                               // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_re) && $stable(out_im)));      // R9
   AST_TW_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
      (k_idx == '0) |-> (tw_re == CW'(1 <<< CF) && tw_im == '0)); // R6

endmodule

bind r2s_fft_stage r2s_fft_stage_chk #(
   .STAGE (STAGE),
   .DW    (DW),
   .CW    (CW),
   .CF    (CF)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_re    (out_re),
   .out_im    (out_im),
   .k_idx     (k_idx),
   .tw_re     (tw_re),
   .tw_im     (tw_im)
);

// File: tb/r2s_fft_stage_bench.sv
`timescale 1ns/1ps
module r2s_fft_stage_bench;

   localparam int LOG2N = 9;
   localparam int STAGE = 3;
   localparam int DW    = 12;
   localparam int H     = 4;
   localparam int G     = 2 * H;
   localparam int NG    = 10;
   localparam int NS    = NG * G;

   logic clk = 1'b0;
   logic rst_n;
   logic in_valid;
   logic signed [DW-1:0] in_re, in_im;
   logic out_valid;
   logic signed [DW-1:0] out_re, out_im;

   always #2.5 clk = ~clk;

   r2s_fft_stage #(.LOG2N(LOG2N), .STAGE(STAGE), .DW(DW), .CW(12), .CF(10)) u_r2s_fft_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_re     (in_re),
      .in_im     (in_im),
      .out_valid (out_valid),
      .out_re    (out_re),
      .out_im    (out_im)
   );

   int xr[NS], xi[NS], yr[NS], yi[NS];
   int total = 0, bad = 0;
   bit done = 1'b0;
   bit exp_v = 1'b0;
   int exp_re = 0, exp_im = 0;
   string exp_tag = "R1";

   function automatic int sat(input int v);
      if (v > 2047) return 2047;
      if (v < -2048) return -2048;
      return v;
   endfunction

   function automatic int rnd(input real x);
      return int'($floor(x + 0.5));
   endfunction

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, expv);
      end
   endtask

   task automatic observe();
      chk(out_valid == exp_v, exp_tag, "out_valid", int'(out_valid), int'(exp_v));
      chk(int'(out_re) == exp_re, exp_tag, "out_re", int'(out_re), exp_re);
      chk(int'(out_im) == exp_im, exp_tag, "out_im", int'(out_im), exp_im);
   endtask

   task automatic drive(input bit v, input int n);
      @(negedge clk);
      observe();
      in_valid = v;
      if (v) begin
         in_re = DW'(xr[n]);
         in_im = DW'(xi[n]);
      end
      if (v && n >= H) begin
         int o, p, gi;
         string ul, gt;
         o  = n - H;
         p  = o % G;
         gi = o / G;
         ul = (p < H) ? "R4" : "R5";
         if (gi == 0) gt = "R3";
         else if (gi == 1) gt = "R6";
         else if (gi <= 3) gt = "R8";
         else gt = "R7";
         exp_tag = {ul, "/", gt};
         exp_v  = 1'b1;
         exp_re = yr[o];
         exp_im = yi[o];
      end else begin
         exp_v   = 1'b0;
         exp_tag = v ? "R1" : "R9";
      end
   endtask

   initial begin
      #1000000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=0 exp=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int n = 0; n < NS; n++) begin
         xr[n] = 0;
         xi[n] = 0;
      end
      // block 0: sparse impulses (pairing)
      xr[1] = 700;   xi[1] = -250;
      xr[6] = -400;  xi[6] = 900;
      // block 1: second half only (twiddle at each offset)
      xr[12] = 1000; xi[12] = 0;
      xr[13] = 0;    xi[13] = 1000;
      xr[14] = -1000; xi[14] = 500;
      xr[15] = 300;  xi[15] = -1000;
      // blocks 2,3: full scale (saturation)
      for (int n = 16; n < 24; n++) begin
         xr[n] = 2047;
         xi[n] = 2047;
      end
      for (int n = 24; n < 28; n++) begin
         xr[n] = -2048;
         xi[n] = -2048;
      end
      for (int n = 28; n < 32; n++) begin
         xr[n] = 2047;
         xi[n] = -2048;
      end
      for (int n = 32; n < NS; n++) begin
         xr[n] = int'($urandom_range(4095, 0)) - 2048;
         xi[n] = int'($urandom_range(4095, 0)) - 2048;
      end
      // reference: sums in the first half of each block, differences in the second
      for (int g = 0; g < NG; g++) begin
         for (int k = 0; k < H; k++) begin
            int ar, ai, br, bi, wr, wi, pr, pi;
            real th;
            th = 6.283185307179586 * (k * (512 / (2 ** STAGE))) / 512.0;
            wr = rnd($cos(th) * 1024.0);
            wi = rnd(-$sin(th) * 1024.0);
            ar = xr[g*G + k];
            ai = xi[g*G + k];
            br = xr[g*G + H + k];
            bi = xi[g*G + H + k];
            pr = (br * wr - bi * wi) >>> 10;
            pi = (br * wi + bi * wr) >>> 10;
            yr[g*G + k]     = sat(ar + pr);
            yi[g*G + k]     = sat(ai + pi);
            yr[g*G + H + k] = sat(ar - pr);
            yi[g*G + H + k] = sat(ai - pi);
         end
      end

      rst_n = 1'b0;
      in_valid = 1'b0;
      in_re = '0;
      in_im = '0;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
      chk(out_re == '0, "R1", "reset out_re", int'(out_re), 0);
      rst_n = 1'b1;

      for (int n = 0; n < NS; n++) begin
         drive(1'b1, n);
         if (n == 2 || n == 5 || n == 19 || n == 37 || n == 50) begin
            drive(1'b0, 0);
            drive(1'b0, 0);
         end
      end
      drive(1'b0, 0);
      @(negedge clk);
      observe();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule